// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit logical address into a physical address by walking a two-level page table in memory. A request carries the address and an access type (read, write or execute). The walker splits the address into a 10-bit outer index, a 10-bit inner index and a 12-bit page offset. It reads one entry per level through a request/response memory port. It returns either the physical address or a trap code.

The table base and the table length are plain configuration inputs. They must hold still while a walk is in flight. The page number is bounded by the length before any memory traffic starts. The outer entry must be valid. The inner entry must be valid and must grant the requested access type. Only one walk is in flight at a time.

Requests enter on a valid/ready pair and are taken only while the walker is idle. Results leave on a valid/ready pair and are held unchanged until accepted. Table reads are issued as a valid/ready request. The matching response is accepted only after its request has been taken, with one outstanding read at most.

Top module: `pgwalk`

## Requirements
- R1: After reset, `req_ready` is 1 and `out_valid`, `mem_req_valid` and `busy` are 0.
- R2: The first table read goes to `cfg_base + 4*outer`, where outer is address bits 31:22.
- R3: An entry holds a 20-bit frame number in bits 31:12 and its valid flag in bit 0. The second read goes to {outer-entry frame, inner, 2'b00}, where inner is address bits 21:12.
- R4: A successful walk returns trap code 0 and a physical address of {inner-entry frame, address bits 11:0}.
- R5: If the page number (address bits 31:12) is greater than or equal to `cfg_len`, the walk returns trap code 1. This happens with no memory read, on the second clock edge after the request is accepted.
- R6: An outer entry with bit 0 clear returns trap code 2 after exactly one memory read.
- R7: An inner entry with bit 0 clear returns trap code 3, whatever its permission bits say.
- R8: Access codes are 0 read, 1 write, 2 execute and 3 reserved. Inner-entry bits 1, 2 and 3 grant read, write and execute. A valid inner entry that lacks the requested grant, or a request with access code 3, returns trap code 4.
- R9: While a walk is in flight, `busy` is 1 and `req_ready` is 0.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_paddr` and `out_trap` hold.
- R11: While `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` hold. The walk waits without producing a result.
- R12: With memory that is always ready and answers one cycle after the request, the result appears 4 edges after acceptance for an outer-level fault and 6 edges after acceptance for a walk that reads both levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Byte address of the outer table |
| cfg_len | input | 21 | Number of mapped pages; page numbers at or above it trap |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_vaddr | input | 32 | Logical address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| mem_req_valid | output | 1 | Table read requested |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry word |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_paddr | output | 32 | Physical address, 0 when trapped |
| out_trap | output | 3 | 0 none, 1 length, 2 outer invalid, 3 inner invalid, 4 protection |
| busy | output | 1 | A walk is in flight |

## Verification
The bench memory is always ready unless a stall is being tested, and it answers on the edge after it takes a read. This gives fixed due times: a length trap 2 edges after acceptance, an outer-level fault 4 edges after, and any walk that reads both levels 6 edges after. The bench counts edges from acceptance, sampling on falling edges, and compares that count with the due time computed for each case. It compares the trap code, the address and the number and addresses of table reads in the same cycle. The stall and hold cases sample for several cycles at fixed offsets to confirm that nothing moves before the handshake completes.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  typedef enum logic [2:0] {
    TRAP_NONE   = 3'd0,
    TRAP_LEN    = 3'd1,
    TRAP_L1_INV = 3'd2,
    TRAP_L2_INV = 3'd3,
    TRAP_PROT   = 3'd4
  } trap_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_READ_L1, ST_READ_L2, ST_DONE, ST_FAULT
  } walk_st_e;

  localparam int ENT_VALID_BIT = 0;
  localparam int ENT_RD_BIT    = 1;
  localparam int ENT_WR_BIT    = 2;
  localparam int ENT_EX_BIT    = 3;
endpackage

// File: rtl/pgwalk_bound.sv
module pgwalk_bound #(
  parameter int VPN_W = 20
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [VPN_W:0]   limit,
  output logic             in_range
);
  assign in_range = {1'b0, vpn} < limit;
endmodule

// File: rtl/pgwalk_entry_chk.sv
module pgwalk_entry_chk
  import pgwalk_pkg::*;
#(
  parameter int ENT_W = 32,
  parameter int OFF_W = 12,
  parameter bit LEAF  = 1'b0
) (
  input  logic [ENT_W-1:0]       entry,
  input  logic [1:0]             acc,
  output logic [ENT_W-OFF_W-1:0] frame,
  output trap_e                  trap
);
  logic perm_ok;
  logic unused_rsv;

  assign frame      = entry[ENT_W-1:OFF_W];
  assign unused_rsv = ^entry[OFF_W-1:ENT_EX_BIT+1];

  always_comb begin
    unique case (acc)
      2'd0:    perm_ok = entry[ENT_RD_BIT];
      2'd1:    perm_ok = entry[ENT_WR_BIT];
      2'd2:    perm_ok = entry[ENT_EX_BIT];
      default: perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (!entry[ENT_VALID_BIT])
      trap = LEAF ? TRAP_L2_INV : TRAP_L1_INV;
    else if (LEAF && !perm_ok)
      trap = TRAP_PROT;
    else
      trap = TRAP_NONE;
  end
endmodule

// File: rtl/pgwalk.sv
module pgwalk
  import pgwalk_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int ADDR_W = 2*IDX_W + OFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cfg_base,
  input  logic [2*IDX_W:0]     cfg_len,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_vaddr,
  input  logic [1:0]           req_acc,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [ADDR_W-1:0]    mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [ADDR_W-1:0]    mem_rsp_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [ADDR_W-1:0]    out_paddr,
  output logic [2:0]           out_trap,
  output logic                 busy
);
  localparam int VPN_W   = 2*IDX_W;
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int LEVELS  = 2;

  walk_st_e            state_q;
  logic [ADDR_W-1:0]   vaddr_q;
  logic [1:0]          acc_q;
  logic                waiting_q;
  logic [FRAME_W-1:0]  l1_frame_q;
  logic [ADDR_W-1:0]   paddr_q;
  trap_e               trap_q;

  logic [VPN_W-1:0]    vpn;
  logic [IDX_W-1:0]    outer_idx, inner_idx;
  logic [ADDR_W-1:0]   l1_addr, l2_addr;
  logic                in_range;
  logic [FRAME_W-1:0]  lvl_frame [LEVELS];
  trap_e               lvl_trap  [LEVELS];

  assign vpn       = vaddr_q[ADDR_W-1:OFF_W];
  assign outer_idx = vaddr_q[ADDR_W-1 -: IDX_W];
  assign inner_idx = vaddr_q[OFF_W +: IDX_W];
  assign l1_addr   = cfg_base + ADDR_W'({outer_idx, 2'b00});
  assign l2_addr   = ADDR_W'({l1_frame_q, inner_idx, 2'b00});

  pgwalk_bound #(.VPN_W(VPN_W)) u_bound (
    .vpn(vpn), .limit(cfg_len), .in_range(in_range)
  );

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    pgwalk_entry_chk #(
      .ENT_W(ADDR_W), .OFF_W(OFF_W), .LEAF(lv == LEVELS-1)
    ) u_chk (
      .entry(mem_rsp_data), .acc(acc_q),
      .frame(lvl_frame[lv]), .trap(lvl_trap[lv])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      vaddr_q    <= '0;
      acc_q      <= '0;
      waiting_q  <= 1'b0;
      l1_frame_q <= '0;
      paddr_q    <= '0;
      trap_q     <= TRAP_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          vaddr_q <= req_vaddr;
          acc_q   <= req_acc;
          paddr_q <= '0;
          trap_q  <= TRAP_NONE;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (in_range) state_q <= ST_READ_L1;
          else begin
            trap_q  <= TRAP_LEN;
            state_q <= ST_FAULT;
          end
        end
        ST_READ_L1: begin
          if (!waiting_q) begin
            if (mem_req_ready) waiting_q <= 1'b1;
          end else if (mem_rsp_valid) begin
            waiting_q <= 1'b0;
            if (lvl_trap[0] != TRAP_NONE) begin
              trap_q  <= lvl_trap[0];
              state_q <= ST_FAULT;
            end else begin
              l1_frame_q <= lvl_frame[0];
              state_q    <= ST_READ_L2;
            end
          end
        end
        ST_READ_L2: begin
          if (!waiting_q) begin
            if (mem_req_ready) waiting_q <= 1'b1;
          end else if (mem_rsp_valid) begin
            waiting_q <= 1'b0;
            if (lvl_trap[1] != TRAP_NONE) begin
              trap_q  <= lvl_trap[1];
              state_q <= ST_FAULT;
            end else begin
              paddr_q <= {lvl_frame[1], vaddr_q[OFF_W-1:0]};
              state_q <= ST_DONE;
            end
          end
        end
        ST_DONE, ST_FAULT: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign busy          = (state_q != ST_IDLE);
  assign mem_req_valid = ((state_q == ST_READ_L1) || (state_q == ST_READ_L2)) && !waiting_q;
  assign mem_req_addr  = (state_q == ST_READ_L2) ? l2_addr : l1_addr;
  assign out_valid     = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign out_paddr     = paddr_q;
  assign out_trap      = trap_q;

  a_r5_len_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> in_range);
  a_r9_one_walk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_paddr) && $stable(out_trap));
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  a_r4_done_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && (out_trap == 3'd0) |-> $past(mem_rsp_valid));
endmodule

// File: tb/pgwalk_bench.sv
module pgwalk_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = BASE;
  logic [20:0] cfg_len = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        mem_req_valid, mem_rdy = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        out_valid, out_rdy = 1'b1, busy;
  logic [31:0] out_paddr;
  logic [2:0]  out_trap;

  int n_tests = 0, n_fail = 0;
  bit done_flag = 0;
  int mem_cnt = 0;
  logic [31:0] last_addr = '0, prev_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwalk u_pgwalk (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_len(cfg_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_rdy), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_rdy), .out_paddr(out_paddr), .out_trap(out_trap),
    .busy(busy)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [19:0] f;
    int o, i, p;
    if (a[31:12] == BASE[31:12]) begin
      o = int'(a[11:2]);
      f = 20'h00100 + 20'(o);
      return {f, 11'd0, (o != 5)};
    end
    o = int'(a[31:12]) - 'h100;
    i = int'(a[11:2]);
    f = 20'h5A000 + 20'(o*64 + i);
    p = (o + i) % 8;
    return {f, 8'd0, 3'(p), ((i % 7) != 3)};
  endfunction

  always_ff @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid && mem_rdy;
    mem_rsp_data  <= mem_word(mem_req_addr);
    if (mem_req_valid && mem_rdy) begin
      mem_cnt   <= mem_cnt + 1;
      prev_addr <= last_addr;
      last_addr <= mem_req_addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_of(input logic [31:0] va, input logic [1:0] acc, input logic [20:0] len,
                           output int trap, output logic [31:0] pa, output int lat, output int reads);
    int o, i, p;
    o = int'(va[31:22]); i = int'(va[21:12]); p = (o + i) % 8;
    pa = '0;
    if ({1'b0, va[31:12]} >= len) begin trap = 1; lat = 2; reads = 0; end
    else if (o == 5) begin trap = 2; lat = 4; reads = 1; end
    else begin
      lat = 6; reads = 2;
      if ((i % 7) == 3) trap = 3;
      else if (acc == 2'd3 || !p[acc]) trap = 4;
      else begin trap = 0; pa = {20'h5A000 + 20'(o*64 + i), va[11:0]}; end
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] acc);
    int et, el, er, n, c0;
    logic [31:0] ep;
    expect_of(va, acc, cfg_len, et, ep, el, er);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 idle ready", 32'(req_ready), 32'd1);
    req_vaddr = va; req_acc = acc; req_valid = 1'b1;
    c0 = mem_cnt;
    @(posedge clk);
    n = 0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      n++;
    end while (!out_valid && n < 60);
    chk(int'(out_trap) == et, "R4-R8 trap", 32'(out_trap), 32'(et));
    chk(out_paddr == ep, "R4 paddr", out_paddr, ep);
    chk(n == el, "R12 latency", 32'(n), 32'(el));
    chk(mem_cnt - c0 == er, "R5 R6 read count", 32'(mem_cnt - c0), 32'(er));
    if (er == 2) begin
      chk(prev_addr == BASE + {20'd0, va[31:22], 2'b00}, "R2 outer addr", prev_addr,
          BASE + {20'd0, va[31:22], 2'b00});
      chk(last_addr == {20'h00100 + 20'(va[31:22]), va[21:12], 2'b00}, "R3 inner addr", last_addr,
          {20'h00100 + 20'(va[31:22]), va[21:12], 2'b00});
    end else if (er == 1) begin
      chk(last_addr == BASE + {20'd0, va[31:22], 2'b00}, "R6 outer addr", last_addr,
          BASE + {20'd0, va[31:22], 2'b00});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] va, hold_pa;
    logic [2:0]  hold_tr;
    int c0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
    chk(busy == 1'b0, "R1 busy", 32'(busy), 32'd0);

    // sweep: outer 0..7, inner 0..7, all access codes; length boundary at page 6*1024+4
    cfg_len = 21'(6*1024 + 4);
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 8; i++)
        for (int a = 0; a < 4; a++) begin
          va = {10'(o), 10'(i), 12'((o*37 + i*11 + a) * 13)};
          walk(va, 2'(a));
        end

    // R5 zero length: every page traps
    cfg_len = '0;
    walk({10'd0, 10'd0, 12'h123}, 2'd0);
    walk({10'd2, 10'd1, 12'hFFF}, 2'd1);
    // full length: top outer indices map
    cfg_len = 21'h100000;
    walk({10'd7, 10'd6, 12'hABC}, 2'd2);
    walk({10'd7, 10'd4, 12'h001}, 2'd1);

    // R11 memory stall: request held, no result
    mem_rdy = 1'b0;
    va = {10'd1, 10'd1, 12'h3C4};
    @(negedge clk);
    req_vaddr = va; req_acc = 2'd1; req_valid = 1'b1;
    c0 = mem_cnt;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(mem_req_valid == 1'b1, "R11 req held", 32'(mem_req_valid), 32'd1);
    chk(mem_req_addr == BASE + 32'd4, "R11 addr held", mem_req_addr, BASE + 32'd4);
    chk(out_valid == 1'b0, "R11 no result", 32'(out_valid), 32'd0);
    chk(mem_cnt == c0, "R11 no read taken", 32'(mem_cnt - c0), 32'd0);
    chk(busy == 1'b1 && req_ready == 1'b0, "R9 busy while stalled", 32'(busy), 32'd1);
    mem_rdy = 1'b1;
    for (int k = 0; k < 20 && !out_valid; k++) @(negedge clk);
    chk(out_trap == 3'd0, "R11 trap after stall", 32'(out_trap), 32'd0);
    chk(out_paddr == {20'h5A000 + 20'd65, 12'h3C4}, "R11 paddr after stall", out_paddr,
        {20'h5A000 + 20'd65, 12'h3C4});

    // R10 result hold under back-pressure
    @(negedge clk);
    out_rdy = 1'b0;
    req_vaddr = {10'd3, 10'd3, 12'h010}; req_acc = 2'd0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    for (int k = 0; k < 20 && !out_valid; k++) @(negedge clk);
    hold_pa = out_paddr; hold_tr = out_trap;
    chk(out_trap == 3'd3, "R7 trap under hold", 32'(out_trap), 32'd3);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1, "R10 valid held", 32'(out_valid), 32'd1);
    chk(out_paddr == hold_pa && out_trap == hold_tr, "R10 data held", 32'(out_trap), 32'(hold_tr));
    chk(req_ready == 1'b0, "R9 not ready while holding", 32'(req_ready), 32'd0);
    out_rdy = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && busy == 1'b0, "R10 released", 32'(out_valid), 32'd0);

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule